// File: doc/BRIEF.md
# Sector Decode Interrupt Status Unit

This block sits next to a multi-sector error-correction decoder and turns its per-sector completion pulses into a register-visible record and a level interrupt. Each time the decoder finishes a sector it pulses `sec_done_i` for one cycle with the sector number on `sec_idx_i`. The unit sets that sector's bit in a completion mask and sets a sticky decode status flag. When the interrupt enable register holds any nonzero value, the flag drives the registered interrupt line.

Software reaches the unit over a small register bus with one-cycle reads. Word offset 0x0 is the control register, where bit 0 starts a decode operation and clears the completion mask, and writing 0 ends the operation. Offset 0x4 is the interrupt enable register. Offset 0x8 is the status register, with the flag in bit 0. Offset 0xC is the completion mask. Reading the status register clears the flag, but only while the enable is nonzero. With the enable at zero the flag survives the read. A sector that finishes after the status read raises the flag again. Software must therefore read the status once more before it closes an operation, or a late sector can leave an interrupt pending.

Top module: `sector_irq_unit`

## Requirements
- R1: After reset the control, enable, status and mask registers all read 0, `irq_o` is 0 and `rvalid_o` is 0.
- R2: A sector pulse while control bit 0 is set sets bit `sec_idx_i` of the mask at offset 0xC. Reading the mask has no side effect.
- R3: A sector pulse while control bit 0 is set sets status bit 0. With a nonzero enable, `irq_o` is 1 from the clock edge that samples the pulse.
- R4: A read returns its data on `rdata_o` with `rvalid_o` high in the cycle after the request. A status read with a nonzero enable returns 1 in bit 0 and clears both the status and `irq_o` at the edge that takes the read.
- R5: A status read while the enable register is 0 returns the status and leaves it set.
- R6: A sector pulse after the status has been cleared sets the status and `irq_o` again, even when every other sector is already done.
- R7: When a sector pulse and a status read fall in the same cycle, the read returns the prior status value and the status ends the cycle set.
- R8: Writing 0 to the enable register (offset 0x4) drops `irq_o` at the edge that takes the write, and the status bit is kept. Writing a nonzero value again raises `irq_o` when the status is set.
- R9: Writing control with bit 0 set clears the mask. Writing control with bit 0 clear ends the operation, and later sector pulses leave both the mask and the status unchanged.
- R10: The control register (offset 0x0, bit 0) and the enable register (offset 0x4, IE_W bits) read back what was written. Writes to 0x8 and 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_done_i | input | 1 | One-cycle pulse: a sector finished decoding |
| sec_idx_i | input | IDX_W | Index of the finished sector |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Level interrupt: status AND nonzero enable |

## Verification
The assertions assume single-cycle sector pulses and bus requests that are either a read or a write, never both. They also assume that an out-of-operation pulse does not coincide with a control write. The bench drives every input at the falling edge, holds each pulse or request for exactly one cycle, and never overlaps a control write with a sector pulse. The one deliberate overlap is a sector pulse landing with a status read, used to show that the completion is not lost.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  // Word select taken from addr[3:2]
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_IE   = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;
endpackage

// File: rtl/sdi_cfg_regs.sv
module sdi_cfg_regs #(
  parameter int DATA_W = 32,
  parameter int IE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_ie_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dec_en_o,
  output logic [IE_W-1:0]   ie_o,
  output logic              ie_any_next_o,
  output logic              new_op_o
);
  logic            en_d, en_q;
  logic [IE_W-1:0] ie_d, ie_q;
  logic            unused_wbits;

  assign unused_wbits = ^wdata_i[DATA_W-1:IE_W];

  always_comb begin
    en_d = en_q;
    ie_d = ie_q;
    if (wr_ctrl_i) en_d = wdata_i[0];
    if (wr_ie_i)   ie_d = wdata_i[IE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= '0;
    end else begin
      if (wr_ctrl_i) en_q <= en_d;
      if (wr_ie_i)   ie_q <= ie_d;
    end
  end

  assign dec_en_o      = en_q;
  assign ie_o          = ie_q;
  assign ie_any_next_o = |ie_d;
  assign new_op_o      = wr_ctrl_i & wdata_i[0];
endmodule

// File: rtl/sdi_done_track.sv
module sdi_done_track #(
  parameter int NSEC  = 16,
  parameter int IDX_W = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NSEC-1:0]  mask_o
);
  logic [NSEC-1:0] mask_d, mask_q;
  logic            upd;

  assign upd = clr_i | hit_i;

  always_comb begin
    mask_d = mask_q;
    if (clr_i) mask_d = '0;
    for (int i = 0; i < NSEC; i++) begin
      if (hit_i && (int'(idx_i) == i)) mask_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (upd) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/sdi_irq_status.sv
module sdi_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic rd_clr_i,
  input  logic ie_any_next_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_d, stat_q, irq_d, irq_q;

  always_comb begin
    stat_d = stat_q;
    if (rd_clr_i) stat_d = 1'b0;
    if (hit_i)    stat_d = 1'b1;   // a completion outranks the clear
    irq_d = stat_d & ie_any_next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sector_irq_unit.sv
module sector_irq_unit
  import sdi_pkg::*;
#(
  parameter int NSEC   = 16,
  parameter int DATA_W = 32,
  parameter int IE_W   = 4,
  parameter int IDX_W  = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_done_i,
  input  logic [IDX_W-1:0]  sec_idx_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic [1:0]        sel;
  logic              wr_ctrl, wr_ie, rd_req, rd_stat, hit;
  logic              dec_en, ie_any_next, new_op, stat_q;
  logic [IE_W-1:0]   ie_q;
  logic [NSEC-1:0]   mask_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;
  logic              unused_abits;

  assign unused_abits = ^addr_i[1:0];
  assign sel     = addr_i[3:2];
  assign wr_ctrl = req_i & we_i & (sel == SEL_CTRL);
  assign wr_ie   = req_i & we_i & (sel == SEL_IE);
  assign rd_req  = req_i & ~we_i;
  assign rd_stat = rd_req & (sel == SEL_STAT) & (|ie_q);
  assign hit     = sec_done_i & dec_en;

  sdi_cfg_regs #(.DATA_W(DATA_W), .IE_W(IE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_ctrl), .wr_ie_i(wr_ie),
    .wdata_i(wdata_i), .dec_en_o(dec_en), .ie_o(ie_q),
    .ie_any_next_o(ie_any_next), .new_op_o(new_op)
  );

  sdi_done_track #(.NSEC(NSEC), .IDX_W(IDX_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr_i(new_op), .hit_i(hit),
    .idx_i(sec_idx_i), .mask_o(mask_q)
  );

  sdi_irq_status u_sts (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .rd_clr_i(rd_stat),
    .ie_any_next_i(ie_any_next), .stat_o(stat_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_CTRL: rdata_d[0]        = dec_en;
      SEL_IE:   rdata_d[IE_W-1:0] = ie_q;
      SEL_STAT: rdata_d[0]        = stat_q;
      SEL_MASK: rdata_d[NSEC-1:0] = mask_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/sdi_checker.sv
module sdi_checker #(
  parameter int NSEC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_i,
  input logic            we_i,
  input logic [3:0]      addr_i,
  input logic            sec_done_i,
  input logic            irq_o,
  input logic            rvalid_o,
  input logic            dec_en,
  input logic [3:0]      ie_q,
  input logic            stat_q,
  input logic [NSEC-1:0] mask_q,
  input logic            wr_ctrl
);
  logic rd_s;
  assign rd_s = req_i && !we_i && (addr_i[3:2] == 2'd2);

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_q) else $error("irq without status"); // R3
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> rvalid_o) else $error("rvalid late"); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && (|ie_q) && !(sec_done_i && dec_en)) |=> (!stat_q && !irq_o))
    else $error("status not cleared"); // R4
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && (ie_q == '0) && stat_q) |=> stat_q) else $error("status lost"); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_done_i && dec_en) |=> stat_q) else $error("completion lost"); // R7
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_done_i && !dec_en && !wr_ctrl) |=> $stable(mask_q))
    else $error("mask moved while idle"); // R9
endmodule

bind sector_irq_unit sdi_checker #(.NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .sec_done_i(sec_done_i), .irq_o(irq_o), .rvalid_o(rvalid_o),
  .dec_en(dec_en), .ie_q(ie_q), .stat_q(stat_q), .mask_q(mask_q),
  .wr_ctrl(wr_ctrl)
);

// File: tb/tb_sector_irq_unit.sv
module tb_sector_irq_unit;
  logic        clk, rst_n, sec_done, req, we, rvalid, irq;
  logic [3:0]  sec_idx, addr;
  logic [31:0] wdata, rdata;
  int          n_run, n_fail;

  sector_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .sec_done_i(sec_done), .sec_idx_i(sec_idx),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;   // 0 idle, 1 write, 2 read, 3 sector pulse
    logic [3:0]  adr;
    logic [15:0] dat;
    logic [15:0] exp;
    logic        eirq;
    logic [7:0]  req_no;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd1, 4'h0, 16'h0001, 16'h0000, 1'b0, 8'd9},   // R9 start op
    '{2'd1, 4'h4, 16'h0001, 16'h0000, 1'b0, 8'd10},  // R10
    '{2'd2, 4'h0, 16'h0000, 16'h0001, 1'b0, 8'd10},  // R10 ctrl readback
    '{2'd2, 4'h4, 16'h0000, 16'h0001, 1'b0, 8'd10},  // R10 ie readback
    '{2'd3, 4'h0, 16'h0000, 16'h0000, 1'b1, 8'd3},   // R3 sector 0
    '{2'd3, 4'h0, 16'h0005, 16'h0000, 1'b1, 8'd3},   // R3 sector 5
    '{2'd2, 4'hC, 16'h0000, 16'h0021, 1'b1, 8'd2},   // R2 mask
    '{2'd2, 4'hC, 16'h0000, 16'h0021, 1'b1, 8'd2},   // R2 no side effect
    '{2'd2, 4'h8, 16'h0000, 16'h0001, 1'b0, 8'd4},   // R4 read clears
    '{2'd2, 4'h8, 16'h0000, 16'h0000, 1'b0, 8'd4},   // R4 now clear
    '{2'd3, 4'h0, 16'h000F, 16'h0000, 1'b1, 8'd6},   // R6 late sector
    '{2'd2, 4'hC, 16'h0000, 16'h8021, 1'b1, 8'd2},   // R2
    '{2'd1, 4'h4, 16'h0000, 16'h0000, 1'b0, 8'd8},   // R8 ie off
    '{2'd2, 4'h8, 16'h0000, 16'h0001, 1'b0, 8'd5},   // R5 read keeps
    '{2'd2, 4'h8, 16'h0000, 16'h0001, 1'b0, 8'd5},   // R5 still set
    '{2'd1, 4'h4, 16'h0003, 16'h0000, 1'b1, 8'd8},   // R8 ie back on
    '{2'd2, 4'h8, 16'h0000, 16'h0001, 1'b0, 8'd4},   // R4
    '{2'd1, 4'h0, 16'h0000, 16'h0000, 1'b0, 8'd9},   // R9 end op
    '{2'd3, 4'h0, 16'h0002, 16'h0000, 1'b0, 8'd9},   // R9 ignored pulse
    '{2'd2, 4'h8, 16'h0000, 16'h0000, 1'b0, 8'd9},   // R9 status untouched
    '{2'd2, 4'hC, 16'h0000, 16'h8021, 1'b0, 8'd9},   // R9 mask untouched
    '{2'd1, 4'h0, 16'h0001, 16'h0000, 1'b0, 8'd9},   // R9 new op
    '{2'd2, 4'hC, 16'h0000, 16'h0000, 1'b0, 8'd9}    // R9 mask cleared
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata; v = rvalid;
  endtask

  task automatic do_pulse(input logic [3:0] idx);
    @(negedge clk); sec_done = 1; sec_idx = idx;
    @(negedge clk); sec_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        v;
    n_run = 0; n_fail = 0;
    rst_n = 0; sec_done = 0; sec_idx = 0; req = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
    check(rvalid == 1'b0, "R1 rvalid", {31'd0, rvalid}, 0);
    for (int a = 0; a < 4; a++) begin
      do_read(4'(a * 4), d, v);
      check(d == 0, "R1 reg", d, 0);
    end

    for (int i = 0; i < NV; i++) begin
      d = 0; v = 1;
      case (VEC[i].op)
        2'd1: do_write(VEC[i].adr, {16'd0, VEC[i].dat});
        2'd2: do_read(VEC[i].adr, d, v);
        2'd3: do_pulse(VEC[i].dat[3:0]);
        default: @(negedge clk);
      endcase
      if (VEC[i].op == 2'd2) begin
        check(d[15:0] == VEC[i].exp, $sformatf("R%0d vec%0d data", VEC[i].req_no, i),
              d, {16'd0, VEC[i].exp});
        check(v == 1'b1, $sformatf("R4 vec%0d rvalid", i), {31'd0, v}, 1);
      end
      check(irq == VEC[i].eirq, $sformatf("R%0d vec%0d irq", VEC[i].req_no, i),
            {31'd0, irq}, {31'd0, VEC[i].eirq});
    end

    // R10 writes to status/mask ignored
    do_write(4'hC, 32'hFFFF);
    do_read(4'hC, d, v);
    check(d == 0, "R10 mask write ignored", d, 0);

    // R7 pulse and status read in the same cycle
    @(negedge clk); req = 1; we = 0; addr = 4'h8; sec_done = 1; sec_idx = 4'd7;
    @(negedge clk); req = 0; sec_done = 0;
    check(rdata == 0, "R7 read returns prior", rdata, 0);
    check(irq == 1'b1, "R7 irq kept", {31'd0, irq}, 1);
    do_read(4'h8, d, v);
    check(d == 1, "R7 status still set", d, 1);
    check(irq == 1'b0, "R4 irq cleared", {31'd0, irq}, 0);
    do_read(4'hC, d, v);
    check(d == 32'h0080, "R2 mask sector 7", d, 32'h0080);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule